// File: doc/BRIEF.md
# Partial-Width General Register File

This block holds the sixteen 64-bit general registers of a 64-bit CISC-style core, together with a 64-bit flags register. It has one write port and two read ports. Each port takes a 4-bit register number, a 2-bit operand-size code and a prefix flag. The size code selects a byte, a word, a doubleword or the full quadword.

On a write, the size code decides what happens to the bits that are not written:

- Byte and word writes merge into the existing contents.
- A doubleword write clears the upper half of the register.
- A quadword write replaces the whole register.

For byte-size accesses, the prefix flag changes how numbers 4 to 7 reach storage:

- Prefix clear: numbers 4 to 7 address the second byte of the first four registers, as the legacy high-byte aliases.
- Prefix set: numbers 4 to 7 address the low byte of registers 4 to 7.

Reads are combinational from the stored state. They return the selected field zero-extended to 64 bits, so a read in the same cycle as a write to the same register sees the value from before the write. The flags port keeps only the lower 32 bits. The upper 32 bits read as zero whatever is written.

Top module: `gprf_top`

## Requirements
- R1: When `wr_en` is high and `wr_sz` is 3 (quadword), the addressed register takes all 64 bits of `wr_data` at the next clock edge.
- R2: When `wr_sz` is 2 (doubleword), bits 31:0 take `wr_data[31:0]` and bits 63:32 of the register become zero.
- R3: When `wr_sz` is 1 (word), only bits 15:0 take `wr_data[15:0]`, and bits 63:16 keep their value.
- R4: When `wr_sz` is 0 (byte) and the prefix is clear, numbers 0 to 3 address bits 7:0 of registers 0 to 3. Numbers 4 to 7 address bits 15:8 of registers 0 to 3, in that order. All other bits keep their value.
- R5: For a byte access with the prefix set, any number n from 0 to 15 addresses bits 7:0 of register n, and the second byte of registers 0 to 3 is out of reach.
- R6: A byte access to numbers 8 to 15 with the prefix clear behaves exactly as with the prefix set.
- R7: A read returns the addressed field in its low bits with all higher bits zero. The field is 8, 16, 32 or 64 bits for size codes 0 to 3, and a high-byte alias returns bits 15:8 of its register in bits 7:0.
- R8: A read of a register being written in the same cycle returns the value held before that write.
- R9: The flags read data holds the last written bits 31:0, and bits 63:32 always read zero.
- R10: A synchronous reset (`rst` high at a clock edge) clears all sixteen registers and the flags.
- R11: For size codes 1, 2 and 3 the prefix flag has no effect on which register is addressed.
- R12: While `wr_en` is low no register changes, and while `fl_we` is low the flags do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write enable |
| wr_num | input | 4 | Write register number |
| wr_sz | input | 2 | Write size code (0 byte, 1 word, 2 doubleword, 3 quadword) |
| wr_pfx | input | 1 | Write prefix flag |
| wr_data | input | 64 | Write data, low bits used per size |
| ra_num | input | 4 | Read port A register number |
| ra_sz | input | 2 | Read port A size code |
| ra_pfx | input | 1 | Read port A prefix flag |
| ra_data | output | 64 | Read port A data, zero-extended |
| rb_num | input | 4 | Read port B register number |
| rb_sz | input | 2 | Read port B size code |
| rb_pfx | input | 1 | Read port B prefix flag |
| rb_data | output | 64 | Read port B data, zero-extended |
| fl_we | input | 1 | Flags write enable |
| fl_wdata | input | 64 | Flags write data |
| fl_rdata | output | 64 | Flags read data, upper half zero |

## Verification
Directed writes use distinct byte patterns so that each size rule can be seen at the quadword view:

- A doubleword over a full-ones register tells zero-extension apart from merging.
- A word over a patterned register shows the untouched upper bits.
- Byte writes with numbers 4 to 7 under each prefix value land in different registers, so a wrong alias is visible.
- A number above 7 with the prefix clear shows the fallback mapping.
- A same-cycle read and write of one register tells the old-value rule apart from a bypass.

Random traffic then mixes all sizes, prefixes and numbers on both read ports against a behavioural model, checked every cycle.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
    localparam int GPR_W    = 64;
    localparam int GPR_N    = 16;
    localparam int NUM_W    = $clog2(GPR_N);
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int DWORD_W  = 2 * WORD_W;
    localparam int FLG_KEEP = 32;
    localparam int ALIAS_N  = 4;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QWORD = 2'd3
    } opsz_e;

    typedef struct packed {
        logic [GPR_N-1:0][GPR_W-1:0] gpr;
        logic [FLG_KEEP-1:0]         flg;
    } rf_state_t;
endpackage

// File: rtl/gprf_slot_map.sv
module gprf_slot_map
    import gprf_pkg::*;
(
    input  logic [NUM_W-1:0] num_i,
    input  logic [1:0]       sz_i,
    input  logic             pfx_i,
    output logic [NUM_W-1:0] idx_o,
    output logic             hi_o
);
    logic is_byte;
    logic in_alias_range;

    always_comb begin
        is_byte        = (opsz_e'(sz_i) == SZ_BYTE);
        in_alias_range = (int'(num_i) >= ALIAS_N) && (int'(num_i) < 2 * ALIAS_N);
        hi_o           = is_byte && !pfx_i && in_alias_range;
        if (hi_o) begin
            idx_o = num_i - NUM_W'(ALIAS_N);
        end else begin
            idx_o = num_i;
        end
    end
endmodule

// File: rtl/gprf_write_merge.sv
module gprf_write_merge
    import gprf_pkg::*;
(
    input  logic [GPR_W-1:0] old_i,
    input  logic [GPR_W-1:0] new_i,
    input  logic [1:0]       sz_i,
    input  logic             hi_i,
    output logic [GPR_W-1:0] res_o
);
    always_comb begin
        res_o = old_i;
        unique case (opsz_e'(sz_i))
            SZ_BYTE: begin
                if (hi_i) begin
                    res_o[WORD_W-1:BYTE_W] = new_i[BYTE_W-1:0];
                end else begin
                    res_o[BYTE_W-1:0] = new_i[BYTE_W-1:0];
                end
            end
            SZ_WORD:  res_o[WORD_W-1:0] = new_i[WORD_W-1:0];
            SZ_DWORD: res_o = {{(GPR_W-DWORD_W){1'b0}}, new_i[DWORD_W-1:0]};
            default:  res_o = new_i;
        endcase
    end
endmodule

// File: rtl/gprf_read_port.sv
module gprf_read_port
    import gprf_pkg::*;
(
    input  logic [GPR_N-1:0][GPR_W-1:0] regs_i,
    input  logic [NUM_W-1:0]            num_i,
    input  logic [1:0]                  sz_i,
    input  logic                        pfx_i,
    output logic [GPR_W-1:0]            data_o
);
    logic [NUM_W-1:0] idx;
    logic             hi;
    logic [GPR_W-1:0] word_sel;

    gprf_slot_map u_map (
        .num_i (num_i),
        .sz_i  (sz_i),
        .pfx_i (pfx_i),
        .idx_o (idx),
        .hi_o  (hi)
    );

    always_comb begin
        word_sel = regs_i[idx];
        data_o   = '0;
        unique case (opsz_e'(sz_i))
            SZ_BYTE:  data_o[BYTE_W-1:0]  = hi ? word_sel[WORD_W-1:BYTE_W]
                                               : word_sel[BYTE_W-1:0];
            SZ_WORD:  data_o[WORD_W-1:0]  = word_sel[WORD_W-1:0];
            SZ_DWORD: data_o[DWORD_W-1:0] = word_sel[DWORD_W-1:0];
            default:  data_o = word_sel;
        endcase
    end
endmodule

// File: rtl/gprf_top.sv
module gprf_top
    import gprf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [NUM_W-1:0] wr_num,
    input  logic [1:0]       wr_sz,
    input  logic             wr_pfx,
    input  logic [GPR_W-1:0] wr_data,
    input  logic [NUM_W-1:0] ra_num,
    input  logic [1:0]       ra_sz,
    input  logic             ra_pfx,
    output logic [GPR_W-1:0] ra_data,
    input  logic [NUM_W-1:0] rb_num,
    input  logic [1:0]       rb_sz,
    input  logic             rb_pfx,
    output logic [GPR_W-1:0] rb_data,
    input  logic             fl_we,
    input  logic [GPR_W-1:0] fl_wdata,
    output logic [GPR_W-1:0] fl_rdata
);
    localparam int RD_PORTS = 2;

    rf_state_t        state_d, state_q;
    logic [NUM_W-1:0] w_idx;
    logic             w_hi;
    logic [GPR_W-1:0] w_merged;

    logic [RD_PORTS-1:0][NUM_W-1:0] rd_num;
    logic [RD_PORTS-1:0][1:0]       rd_sz;
    logic [RD_PORTS-1:0]            rd_pfx;
    logic [RD_PORTS-1:0][GPR_W-1:0] rd_data;

    gprf_slot_map u_wmap (
        .num_i (wr_num),
        .sz_i  (wr_sz),
        .pfx_i (wr_pfx),
        .idx_o (w_idx),
        .hi_o  (w_hi)
    );

    gprf_write_merge u_merge (
        .old_i (state_q.gpr[w_idx]),
        .new_i (wr_data),
        .sz_i  (wr_sz),
        .hi_i  (w_hi),
        .res_o (w_merged)
    );

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.gpr[w_idx] = w_merged;
        end
        if (fl_we) begin
            state_d.flg = fl_wdata[FLG_KEEP-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_num  = {rb_num, ra_num};
    assign rd_sz   = {rb_sz, ra_sz};
    assign rd_pfx  = {rb_pfx, ra_pfx};

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        gprf_read_port u_rd (
            .regs_i (state_q.gpr),
            .num_i  (rd_num[p]),
            .sz_i   (rd_sz[p]),
            .pfx_i  (rd_pfx[p]),
            .data_o (rd_data[p])
        );
    end

    assign ra_data  = rd_data[0];
    assign rb_data  = rd_data[1];
    assign fl_rdata = {{(GPR_W-FLG_KEEP){1'b0}}, state_q.flg};
endmodule

// File: rtl/gprf_chk.sv
module gprf_chk
    import gprf_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic [NUM_W-1:0]            wr_num,
    input logic [1:0]                  wr_sz,
    input logic [GPR_W-1:0]            wr_data,
    input logic                        fl_we,
    input logic [GPR_W-1:0]            fl_rdata,
    input logic [GPR_N-1:0][GPR_W-1:0] gpr
);
    AST_QWORD_FULL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sz == 2'd3) |=> gpr[$past(wr_num)] == $past(wr_data)); // R1

    AST_DWORD_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sz == 2'd2) |=> gpr[$past(wr_num)][GPR_W-1:DWORD_W] == '0); // R2

    AST_WORD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sz == 2'd1)
        |=> gpr[$past(wr_num)][GPR_W-1:WORD_W] == $past(gpr[wr_num][GPR_W-1:WORD_W])); // R3

    AST_FLAGS_UPPER: assert property (@(posedge clk) disable iff (rst)
        fl_rdata[GPR_W-1:FLG_KEEP] == '0); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (gpr == '0 && fl_rdata == '0)); // R10

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(gpr)); // R12

    AST_FLAGS_STABLE: assert property (@(posedge clk) disable iff (rst)
        !fl_we |=> $stable(fl_rdata)); // R12
endmodule

bind gprf_top gprf_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_num   (wr_num),
    .wr_sz    (wr_sz),
    .wr_data  (wr_data),
    .fl_we    (fl_we),
    .fl_rdata (fl_rdata),
    .gpr      (state_q.gpr)
);

// File: tb/test_gprf_top.sv
module test_gprf_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_num;
    logic [1:0]  wr_sz;
    logic        wr_pfx;
    logic [63:0] wr_data;
    logic [3:0]  ra_num;
    logic [1:0]  ra_sz;
    logic        ra_pfx;
    logic [63:0] ra_data;
    logic [3:0]  rb_num;
    logic [1:0]  rb_sz;
    logic        rb_pfx;
    logic [63:0] rb_data;
    logic        fl_we;
    logic [63:0] fl_wdata;
    logic [63:0] fl_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [63:0] m_rf [16];
    logic [63:0] m_fl;

    always #2.5 clk = ~clk;

    gprf_top i_gprf_top (
        .clk, .rst, .wr_en, .wr_num, .wr_sz, .wr_pfx, .wr_data,
        .ra_num, .ra_sz, .ra_pfx, .ra_data,
        .rb_num, .rb_sz, .rb_pfx, .rb_data,
        .fl_we, .fl_wdata, .fl_rdata
    );

    // Behavioural model: target register index and bit offset of an access
    function automatic void locate(input logic [3:0] n, input logic [1:0] s,
                                   input logic p, output int idx, output int lo);
        if (s == 2'd0 && !p && n >= 4 && n <= 7) begin
            idx = n - 4;
            lo  = 8;
        end else begin
            idx = n;
            lo  = 0;
        end
    endfunction

    function automatic logic [63:0] model_read(input logic [3:0] n,
                                               input logic [1:0] s, input logic p);
        int idx, lo, bits;
        logic [63:0] v;
        locate(n, s, p, idx, lo);
        bits = 8 << s;
        v = m_rf[idx] >> lo;
        for (int b = 0; b < 64; b++) if (b >= bits) v[b] = 1'b0;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < 16; r++) m_rf[r] = 64'h0;
            m_fl = 64'h0;
        end else begin
            if (wr_en) begin
                int idx, lo, bits;
                locate(wr_num, wr_sz, wr_pfx, idx, lo);
                bits = 8 << wr_sz;
                if (wr_sz == 2'd2) m_rf[idx] = 64'h0;
                for (int b = 0; b < bits; b++) m_rf[idx][lo + b] = wr_data[b];
            end
            if (fl_we) m_fl = {32'h0, fl_wdata[31:0]};
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic write(input logic [3:0] n, input logic [1:0] s,
                         input logic p, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_num = n; wr_sz = s; wr_pfx = p; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic read_a(input string tag, input logic [3:0] n, input logic [1:0] s,
                          input logic p, input logic [63:0] exp);
        ra_num = n; ra_sz = s; ra_pfx = p;
        #1;
        check(tag, ra_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1; wr_en = 0; wr_num = 0; wr_sz = 0; wr_pfx = 0; wr_data = 0;
        ra_num = 0; ra_sz = 0; ra_pfx = 0; rb_num = 0; rb_sz = 0; rb_pfx = 0;
        fl_we = 0; fl_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: reset state
        for (int r = 0; r < 16; r++) read_a("R10 reset reg", 4'(r), 2'd3, 1'b0, 64'h0);
        check("R10 reset flags", fl_rdata, 64'h0);

        write(4'd3, 2'd3, 1'b0, 64'h1122_3344_5566_7788);
        read_a("R1 qword write", 4'd3, 2'd3, 1'b0, 64'h1122_3344_5566_7788);

        write(4'd3, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        write(4'd3, 2'd2, 1'b0, 64'hFFFF_FFFF_AABB_CCDD);
        read_a("R2 dword zero-extend", 4'd3, 2'd3, 1'b0, 64'h0000_0000_AABB_CCDD);

        write(4'd5, 2'd3, 1'b0, 64'h0123_4567_89AB_CDEF);
        write(4'd5, 2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_5A5A);
        read_a("R3 word merge", 4'd5, 2'd3, 1'b0, 64'h0123_4567_89AB_5A5A);

        write(4'd0, 2'd3, 1'b0, 64'h1111_1111_1111_1111);
        write(4'd4, 2'd3, 1'b0, 64'h4444_4444_4444_4444);
        write(4'd4, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FF77);
        read_a("R4 high byte into reg0", 4'd0, 2'd3, 1'b0, 64'h1111_1111_1111_7711);
        read_a("R4 reg4 untouched", 4'd4, 2'd3, 1'b0, 64'h4444_4444_4444_4444);
        write(4'd1, 2'd0, 1'b0, 64'h0000_0000_0000_00E5);
        read_a("R4 low byte reg1", 4'd1, 2'd3, 1'b0, 64'h0000_0000_0000_00E5);

        write(4'd4, 2'd0, 1'b1, 64'h0000_0000_0000_0099);
        read_a("R5 prefixed low byte reg4", 4'd4, 2'd3, 1'b0, 64'h4444_4444_4444_4499);
        read_a("R5 reg0 unchanged", 4'd0, 2'd3, 1'b0, 64'h1111_1111_1111_7711);
        write(4'd12, 2'd0, 1'b1, 64'h0000_0000_0000_003C);
        read_a("R5 extended reg byte", 4'd12, 2'd3, 1'b0, 64'h0000_0000_0000_003C);

        write(4'd9, 2'd3, 1'b0, 64'h9999_9999_9999_9999);
        write(4'd9, 2'd0, 1'b0, 64'h0000_0000_0000_00E1);
        read_a("R6 unprefixed byte 9", 4'd9, 2'd3, 1'b0, 64'h9999_9999_9999_99E1);
        read_a("R6 unprefixed byte read 9", 4'd9, 2'd0, 1'b0, 64'h0000_0000_0000_00E1);

        read_a("R7 word read", 4'd3, 2'd1, 1'b0, 64'h0000_0000_0000_CCDD);
        read_a("R7 high byte read", 4'd7, 2'd0, 1'b0, 64'h0000_0000_0000_00CC);
        read_a("R7 dword read", 4'd5, 2'd2, 1'b0, 64'h0000_0000_89AB_5A5A);

        // R8: same-cycle read returns the old value
        @(negedge clk);
        wr_en = 1; wr_num = 4'd3; wr_sz = 2'd3; wr_pfx = 0; wr_data = 64'h5555_5555_5555_5555;
        ra_num = 4'd3; ra_sz = 2'd3; ra_pfx = 0;
        #1 check("R8 old value during write", ra_data, 64'h0000_0000_AABB_CCDD);
        @(negedge clk);
        wr_en = 0;
        #1 check("R8 new value after edge", ra_data, 64'h5555_5555_5555_5555);

        // R11: prefix has no effect on non-byte sizes
        write(4'd2, 2'd3, 1'b0, 64'h2222_2222_2222_2222);
        write(4'd6, 2'd3, 1'b0, 64'h6666_6666_6666_6666);
        write(4'd6, 2'd1, 1'b0, 64'h0000_0000_0000_BEEF);
        read_a("R11 word to reg6", 4'd6, 2'd3, 1'b1, 64'h6666_6666_6666_BEEF);
        read_a("R11 reg2 untouched", 4'd2, 2'd3, 1'b0, 64'h2222_2222_2222_2222);

        // R12: disabled write leaves state
        @(negedge clk);
        wr_en = 0; wr_num = 4'd2; wr_sz = 2'd3; wr_data = 64'h0;
        @(negedge clk);
        read_a("R12 no write when disabled", 4'd2, 2'd3, 1'b0, 64'h2222_2222_2222_2222);

        // R9: flags
        @(negedge clk);
        fl_we = 1; fl_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        fl_we = 0; fl_wdata = 64'h0;
        #1 check("R9 flags upper zero", fl_rdata, 64'h0000_0000_FFFF_FFFF);
        @(negedge clk);
        #1 check("R12 flags hold", fl_rdata, 64'h0000_0000_FFFF_FFFF);

        // Random traffic against the model (R7, R8)
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            wr_en   = $urandom_range(0, 1);
            wr_num  = 4'($urandom);
            wr_sz   = 2'($urandom);
            wr_pfx  = 1'($urandom);
            wr_data = {$urandom, $urandom};
            ra_num  = 4'($urandom); ra_sz = 2'($urandom); ra_pfx = 1'($urandom);
            rb_num  = 4'($urandom); rb_sz = 2'($urandom); rb_pfx = 1'($urandom);
            if ((i % 7) == 0) ra_num = wr_num;
            fl_we    = ($urandom_range(0, 3) == 0);
            fl_wdata = {$urandom, $urandom};
            #1;
            check("R7 random port A", ra_data, model_read(ra_num, ra_sz, ra_pfx));
            check("R7 random port B", rb_data, model_read(rb_num, rb_sz, rb_pfx));
            check("R9 random flags", fl_rdata, m_fl);
        end
        @(negedge clk);
        wr_en = 0; fl_we = 0;

        // R10: reset clears after traffic
        rst = 1;
        @(negedge clk);
        rst = 0;
        for (int r = 0; r < 16; r++) read_a("R10 reset after traffic", 4'(r), 2'd3, 1'b0, 64'h0);
        check("R10 flags after reset", fl_rdata, 64'h0);
        finish_run();
    end
endmodule